// File: doc/BRIEF.md
# Eight-bit Timer with Two Compare Channels

This block is an up-counter that advances by one on each cycle where a single-cycle tick enable is high. The tick is generated by a separate clock-select unit. Two compare channels, A and B, each hold a compare value. When the count equals a channel's value on a tick, that channel changes its waveform output bit as its action field selects and raises a sticky match flag.

The counter either runs free and wraps from all-ones to zero, setting an overflow flag, or it runs in clear-on-compare mode. In that mode, either channel's compare value can serve as the top of the count.

Software reaches the block through a small register interface. Through it, software writes the counter, the compare values, the mode, the actions and the flag clears, and it can strobe a forced compare on either channel. A forced compare drives the waveform output the way a real match would. It sets no flag and never clears the counter. A write to the counter hides the compare match on the tick that follows it.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the count, both compare values, the control register, all flags and both waveform outputs are 0.
- R2: The count rises by one only on a cycle with `tick_i` high and holds otherwise. In free-running mode (CTRL bit 0 = 0) a tick at 255 gives 0 and sets the overflow flag, FLAGS bit 2.
- R3: In clear-on-compare mode (CTRL bit 0 = 1), CTRL bit 1 picks the top value: 0 picks compare A and 1 picks compare B. A tick on which the count equals that top value and a match is evaluated makes the next count 0. The overflow flag is never set in this mode.
- R4: The action field is CTRL[3:2] for channel A and CTRL[5:4] for channel B. On a tick where the count equals the channel's compare value, the field drives the channel's output: 00 keeps it, 01 inverts it, 10 drives 0 and 11 drives 1. `wave_o[0]` is channel A and `wave_o[1]` is channel B.
- R5: The match flags are FLAGS bit 0 (A) and bit 1 (B). A flag is set on its match tick and stays set until a 1 is written to its bit. If a match and a clear fall in the same cycle, the set wins. Writing 1 to FLAGS bit 2 clears the overflow flag.
- R6: Writing 1 to FORCE bit 0 (A) or bit 1 (B) applies that channel's action to its output in that cycle. It sets no flag and leaves the count unchanged, even when that channel supplies the top value. FORCE always reads as 0.
- R7: A write to COUNT loads the value and suppresses every compare match, including the clear-on-compare reset, on the next tick. The write cycle is itself suppressed. Matching resumes on the tick after that. A counter write wins over a tick in the same cycle.
- R8: CTRL bits 7:6 are reserved: they read 0 and writes to them are ignored.
- R9: The register map is: address 0 CTRL, 1 FORCE, 2 COUNT, 3 CMPA, 4 CMPB, 5 FLAGS. Addresses 6 and 7 read 0 and ignore writes. Reads are combinational from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle count enable from the clock-select unit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | CNT_W | Register write data |
| rd_data_o | output | CNT_W | Register read data at `addr_i` |
| wave_o | output | 2 | Waveform outputs, bit 0 channel A, bit 1 channel B |

## Verification
The bench builds the block with the default CNT_W of 8, so the register fields line up with the counter width. Every count value, including the 255-to-0 wrap, is reachable within a few hundred ticks. Small compare values bring clear-on-compare periods and match and force collisions within a few dozen cycles. Long random runs with mixed tick rates and register writes make counter writes land right before top matches and flag clears coincide with matches.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmp_act_e;

  localparam int unsigned REG_AW  = 3;
  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned CTRL_W  = 2 + 2 * NUM_CH;

  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_FORCE = 3'd1;
  localparam logic [REG_AW-1:0] A_COUNT = 3'd2;
  localparam logic [REG_AW-1:0] A_CMPA  = 3'd3;
  localparam logic [REG_AW-1:0] A_CMPB  = 3'd4;
  localparam logic [REG_AW-1:0] A_FLAGS = 3'd5;

  function automatic logic apply_act(input cmp_act_e act, input logic cur);
    logic res;
    unique case (act)
      ACT_TOGGLE: res = ~cur;
      ACT_CLEAR:  res = 1'b0;
      ACT_SET:    res = 1'b1;
      default:    res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ctc_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o,
  output logic             block_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q, count_d;
  logic             block_q, block_d;

  always_comb begin
    count_d = count_q;
    block_d = block_q;
    if (wr_i) begin
      count_d = wr_data_i;
      block_d = 1'b1;
    end else if (tick_i) begin
      block_d = 1'b0;
      if (clear_i) count_d = '0;
      else         count_d = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      block_q <= 1'b0;
    end else begin
      count_q <= count_d;
      block_q <= block_d;
    end
  end

  assign wrap_o  = tick_i && !wr_i && !ctc_i && (count_q == CNT_MAX);
  assign count_o = count_q;
  assign block_o = block_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_i) |=> $stable(count_q)); // R2
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_i && !ctc_i && count_q == CNT_MAX) |=> (count_q == '0)); // R2
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (count_q == $past(wr_data_i))); // R7

endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             force_i,
  input  logic [1:0]       act_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o,
  output logic             flag_o,
  output logic             wave_o
);

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             flag_q, flag_d;
  logic             wave_q, wave_d;
  logic             hit;

  assign hit = eval_i && (count_i == cmp_q);

  always_comb begin
    cmp_d  = cmp_wr_i ? wr_data_i : cmp_q;
    flag_d = flag_q;
    if (hit)             flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
    wave_d = wave_q;
    if (hit || force_i) wave_d = apply_act(cmp_act_e'(act_i), wave_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
      wave_q <= wave_d;
    end
  end

  assign cmp_o  = cmp_q;
  assign hit_o  = hit;
  assign flag_o = flag_q;
  assign wave_o = wave_q;

  AST_FLAG_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit)); // R6
  AST_WAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !force_i) |=> $stable(wave_q)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr_i) |=> flag_q); // R5

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                wr_en_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [CNT_W-1:0]    wr_data_i,
  output logic [CNT_W-1:0]    rd_data_o,
  output logic [NUM_CH-1:0]   wave_o
);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ovf_q, ovf_d;

  logic [CNT_W-1:0]  count;
  logic              block, wrap;
  logic              cnt_wr, ctrl_wr, flags_wr, force_wr;
  logic              eval, ctc, top_sel, top_hit;

  logic [NUM_CH-1:0]            hit, flag, force_v, cmp_wr;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp;

  assign cnt_wr   = wr_en_i && (addr_i == A_COUNT);
  assign ctrl_wr  = wr_en_i && (addr_i == A_CTRL);
  assign flags_wr = wr_en_i && (addr_i == A_FLAGS);
  assign force_wr = wr_en_i && (addr_i == A_FORCE);
  assign cmp_wr[0] = wr_en_i && (addr_i == A_CMPA);
  assign cmp_wr[1] = wr_en_i && (addr_i == A_CMPB);

  assign ctc     = ctrl_q[0];
  assign top_sel = ctrl_q[1];
  assign eval    = tick_i && !block && !cnt_wr;
  assign top_hit = ctc && hit[top_sel];

  cmp_timer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_i      (cnt_wr),
    .wr_data_i (wr_data_i),
    .ctc_i     (ctc),
    .clear_i   (top_hit),
    .count_o   (count),
    .block_o   (block),
    .wrap_o    (wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign force_v[g] = force_wr && wr_data_i[g];
    cmp_timer_channel #(.CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .eval_i     (eval),
      .count_i    (count),
      .cmp_wr_i   (cmp_wr[g]),
      .wr_data_i  (wr_data_i),
      .force_i    (force_v[g]),
      .act_i      (ctrl_q[2+2*g +: 2]),
      .flag_clr_i (flags_wr && wr_data_i[g]),
      .cmp_o      (cmp[g]),
      .hit_o      (hit[g]),
      .flag_o     (flag[g]),
      .wave_o     (wave_o[g])
    );
  end

  always_comb begin
    ctrl_d = ctrl_wr ? wr_data_i[CTRL_W-1:0] : ctrl_q;
    ovf_d  = ovf_q;
    if (wrap)                              ovf_d = 1'b1;
    else if (flags_wr && wr_data_i[NUM_CH]) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ovf_q  <= ovf_d;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rd_data_o = CNT_W'(ctrl_q);
      A_COUNT: rd_data_o = count;
      A_CMPA:  rd_data_o = cmp[0];
      A_CMPB:  rd_data_o = cmp[1];
      A_FLAGS: rd_data_o = CNT_W'({ovf_q, flag});
      default: rd_data_o = '0;
    endcase
  end

  AST_MASK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (hit == '0)); // R7
  AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_wr && top_hit) |=> (count == '0)); // R3
  AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == A_FORCE) |-> (rd_data_o == '0)); // R6
  AST_NO_OVF_IN_CTC: assert property (@(posedge clk) disable iff (!rst_n)
    (ctc && !ctrl_wr && !ovf_q) |=> !ovf_q); // R3

endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick_i, wr_en_i;
  logic [2:0]   addr_i;
  logic [W-1:0] wr_data_i, rd_data_o;
  logic [1:0]   wave_o;

  cmp_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .wave_o(wave_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  // reference state
  int m_cnt, m_ca, m_cb, m_ctrl;
  bit m_fa, m_fb, m_ov, m_wa, m_wb, m_blk;

  function automatic int ref_read(int ad);
    case (ad)
      0: return m_ctrl;
      2: return m_cnt;
      3: return m_ca;
      4: return m_cb;
      5: return {m_ov, m_fb, m_fa};
      default: return 0;
    endcase
  endfunction

  function automatic bit act(int code, bit cur);
    case (code)
      1: return !cur;
      2: return 1'b0;
      3: return 1'b1;
      default: return cur;
    endcase
  endfunction

  task automatic check(string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, got, exp, $time);
    end
  endtask

  function automatic string reg_req(int ad);
    case (ad)
      0: return "R8";
      1: return "R6";
      2: return "R2";
      5: return "R5";
      default: return "R9";
    endcase
  endfunction

  // one cycle: drive after negedge, compare, advance model at posedge
  task automatic cyc(bit tk, bit we, int ad, int wd);
    bit cw, ev, ha, hb, clr, fza, fzb;
    int n_cnt;
    tick_i = tk; wr_en_i = we; addr_i = 3'(ad); wr_data_i = W'(wd);
    #1;
    check({reg_req(ad), " read"}, int'(rd_data_o), ref_read(ad));
    check("R4 wave", int'(wave_o), {m_wb, m_wa});
    cw  = we && ad == 2;
    ev  = tk && !m_blk && !cw;
    ha  = ev && m_cnt == m_ca;
    hb  = ev && m_cnt == m_cb;
    fza = we && ad == 1 && wd[0];
    fzb = we && ad == 1 && wd[1];
    clr = m_ctrl[0] && (m_ctrl[1] ? hb : ha);
    n_cnt = cw ? (wd & 255) : tk ? (clr ? 0 : (m_cnt + 1) % 256) : m_cnt;
    @(posedge clk);
    if (tk && !cw && !m_ctrl[0] && m_cnt == 255) m_ov = 1;
    else if (we && ad == 5 && wd[2]) m_ov = 0;
    if (ha) m_fa = 1; else if (we && ad == 5 && wd[0]) m_fa = 0;
    if (hb) m_fb = 1; else if (we && ad == 5 && wd[1]) m_fb = 0;
    if (ha || fza) m_wa = act((m_ctrl >> 2) & 3, m_wa);
    if (hb || fzb) m_wb = act((m_ctrl >> 4) & 3, m_wb);
    m_blk = cw ? 1 : tk ? 0 : m_blk;
    m_cnt = n_cnt;
    if (we && ad == 0) m_ctrl = wd & 8'h3F;
    if (we && ad == 3) m_ca = wd & 255;
    if (we && ad == 4) m_cb = wd & 255;
    @(negedge clk);
  endtask

  task automatic wr(int ad, int wd); cyc(0, 1, ad, wd); endtask
  task automatic ticks(int n, int ad);
    for (int i = 0; i < n; i++) cyc(1, 0, ad, 0);
  endtask

  bit done = 0;
  initial begin
    int cyc_n = 0;
    while (!done) begin
      @(posedge clk);
      cyc_n++;
      if (cyc_n > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; tick_i = 0; wr_en_i = 0; addr_i = 0; wr_data_i = 0;
    m_cnt = 0; m_ca = 0; m_cb = 0; m_ctrl = 0;
    m_fa = 0; m_fb = 0; m_ov = 0; m_wa = 0; m_wb = 0; m_blk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R1 reset";
    for (int a = 0; a < 8; a++) cyc(0, 0, a, 0);

    tag = "R2 free run";
    ticks(10, 2);
    for (int i = 0; i < 5; i++) cyc(0, 0, 2, 0);
    ticks(250, 5);
    wr(5, 4);
    cyc(0, 0, 5, 0);

    tag = "R4 actions";
    wr(3, 5); wr(4, 9); wr(0, 8'h34); wr(2, 0);
    ticks(30, 2);
    wr(0, 8'hE8);             // R8: reserved bits written
    cyc(0, 0, 0, 0);
    wr(2, 0);
    ticks(12, 5);

    tag = "R5 flags";
    wr(5, 7);
    cyc(0, 0, 5, 0);
    wr(2, 4);
    cyc(1, 1, 5, 1);          // tick: count write masks? no, write is FLAGS here
    ticks(3, 5);
    wr(2, 8);
    cyc(1, 0, 5, 0);
    cyc(1, 1, 5, 2);          // match on B coincides with clear of B: set wins
    cyc(0, 0, 5, 0);

    tag = "R3 top A";
    wr(5, 7); wr(3, 10); wr(0, 8'h05); wr(2, 0);
    ticks(40, 2);
    cyc(0, 0, 5, 0);
    tag = "R3 top B";
    wr(4, 6); wr(0, 8'h33);
    ticks(30, 2);

    tag = "R6 force";
    wr(5, 7); wr(0, 8'h05); wr(3, 10); wr(2, 10);
    cyc(0, 1, 1, 3);
    cyc(0, 0, 2, 0);
    cyc(0, 0, 5, 0);
    cyc(0, 1, 1, 1);
    cyc(0, 0, 1, 0);
    wr(0, 8'h3D);
    cyc(0, 1, 1, 2);
    cyc(0, 1, 1, 3);
    cyc(0, 0, 5, 0);

    tag = "R7 mask";
    wr(0, 8'h05); wr(3, 10); wr(5, 7);
    wr(2, 10);
    cyc(1, 0, 2, 0);          // masked: count goes to 11, no toggle
    cyc(0, 0, 5, 0);
    ticks(3, 2);
    wr(2, 9);
    ticks(3, 2);              // 9 is masked tick, then 10 matches and clears
    cyc(1, 1, 2, 10);         // write wins over tick
    cyc(0, 0, 2, 0);
    ticks(2, 2);

    tag = "R9 map";
    wr(6, 8'hFF); wr(7, 8'hFF);
    for (int a = 0; a < 8; a++) cyc(0, 0, a, 0);

    tag = "random R2 R3 R4 R5 R6 R7";
    for (int i = 0; i < 6000; i++) begin
      int r = int'($urandom_range(0, 99));
      bit tk = (r % 3) != 0;
      bit we = r < 22;
      int ad = int'($urandom_range(0, 7));
      int wd = int'($urandom_range(0, 255));
      if (we && (ad == 3 || ad == 4)) wd = wd % 24;
      if (we && ad == 2) wd = (r < 8) ? (wd % 24) : wd;
      cyc(tk, we, ad, wd);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule